// File: doc/BRIEF.md
# Body-Bias Regulator Transition Sequencer

This block replaces the boot firmware that programs a body-bias regulator for a new operating point. A one-cycle `start` pulse presents an operating-point code, a preset result from an optional fuse step, three register addresses and a precomputed settle count. The block then issues a fixed series of register writes through a simple write-strobe port, one per cycle, and polls a transition-done status bit through a readback port.

Writes to the setup and control registers are set-bit operations computed against internal shadow copies of those registers. The status register is write-one-to-clear. It is cleared before the regulator is armed and again after the transition ends. If the regulator never reports completion within a bounded number of poll cycles, the block raises an error flag and still finishes. Requests that cannot be served end at once with a `skipped` pulse and no writes at all.

Top module: `bias_seq`

## Requirements
- R1: A `start` pulse sampled while idle with a valid request raises `busy` in the next cycle. `busy` stays high until the sequence ends, and no write strobe is issued while `busy` is low.
- R2: Operating-point code 1 (fast) selects forward bias, setup bit 2, and the fast select bit, control bit 4.
- R3: Operating-point code 2 (slow) selects reverse bias, setup bit 1, and the slow select bit, control bit 3.
- R4: Any other operating-point code ends the request with a one-cycle `skipped` pulse and no writes.
- R5: If any of the setup, control or status addresses is zero, the request is skipped with no writes.
- R6: With `preset_en` high and `preset_ok` low, the request is skipped with no writes. With `preset_ok` high, the request runs normally.
- R7: The first two writes are zero to the setup register and then zero to the control register.
- R8: The third write puts the settle count into setup bits [15:8], all other bits zero.
- R9: The fourth write sends 0x80 (done bit 7) to the status register, before any bias type is selected.
- R10: The fifth write sets the bias-type bit together with enable bit 0 in setup, keeping the settle field. The sixth write sets the select bit together with request bit 2 in control.
- R11: If the done bit stays low for TIMEOUT poll cycles, `timeout_err` goes high and the sequence still finishes. The busy time is then TIMEOUT+7 cycles.
- R12: The last write always sends 0x80 to the status register, whether the transition completed or timed out.
- R13: `done` pulses for one cycle after the final write, with `timeout_err` low on success. `timeout_err` clears at the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse |
| opp_code | input | OPP_W | Requested operating point (1 fast, 2 slow) |
| preset_en | input | 1 | Fuse preset step is in use |
| preset_ok | input | 1 | Fuse preset step succeeded |
| settle_cnt | input | CNT_W | Precomputed regulator settle count |
| setup_addr | input | AW | Setup register address |
| ctrl_addr | input | AW | Control register address |
| stat_addr | input | AW | Status register address |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| rd_addr | output | AW | Readback address (status while polling) |
| rd_data | input | DW | Readback data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| skipped | output | 1 | Request rejected pulse |
| timeout_err | output | 1 | Poll timed out |

## Verification
The bench plants a pending done bit before a request whose regulator never answers. A design that skipped the first status clear would see that stale bit and report success instead of timing out. It tries each abort cause (bad code, zero address, failed preset) and checks that not a single write leaks out, since a design that decides late would emit a clearing write first. It compares exact write data in order, which catches a settle field at the wrong offset, a swapped fast/slow mapping, or a lost shadow bit in the read-modify-write. It also counts busy cycles to pin the timeout bound and confirms the closing status clear occurs on both the success and the timeout path.

// File: rtl/bias_seq.sv
module bias_seq #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int OPP_W = 2,
  parameter int OPP_FAST = 1,
  parameter int OPP_SLOW = 2,
  parameter int CNT_W = 8,
  parameter int CNT_LSB = 8,
  parameter int EN_BIT = 0,
  parameter int RBB_BIT = 1,
  parameter int FBB_BIT = 2,
  parameter int REQ_BIT = 2,
  parameter int SLOW_SEL_BIT = 3,
  parameter int FAST_SEL_BIT = 4,
  parameter int DONE_BIT = 7,
  parameter int TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPP_W-1:0] opp_code,
  input  logic             preset_en,
  input  logic             preset_ok,
  input  logic [CNT_W-1:0] settle_cnt,
  input  logic [AW-1:0]    setup_addr,
  input  logic [AW-1:0]    ctrl_addr,
  input  logic [AW-1:0]    stat_addr,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    rd_data,
  output logic             busy,
  output logic             done,
  output logic             skipped,
  output logic             timeout_err
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [DW-1:0] DONE_MASK = DW'(1) << DONE_BIT;

  typedef enum logic [3:0] {
    IDLE, CLR_SETUP, CLR_CTRL, WR_CNT, CLR_ST1, WR_TYPE, WR_REQ, POLL, CLR_ST2
  } st_t;

  st_t st;
  logic [DW-1:0] setup_sh, ctrl_sh;
  logic [CNT_W-1:0] cnt_q;
  logic fast_q;
  logic [TW-1:0] tmo;

  wire is_fast = opp_code == OPP_W'(OPP_FAST);
  wire is_slow = opp_code == OPP_W'(OPP_SLOW);
  wire reject = setup_addr == '0 || ctrl_addr == '0 || stat_addr == '0 ||
                !(is_fast || is_slow) || (preset_en && !preset_ok);

  wire [DW-1:0] type_bits = fast_q ? (DW'(1) << FBB_BIT) : (DW'(1) << RBB_BIT);
  wire [DW-1:0] sel_bits  = fast_q ? (DW'(1) << FAST_SEL_BIT) : (DW'(1) << SLOW_SEL_BIT);

  assign busy    = st != IDLE;
  assign rd_addr = (st == POLL) ? stat_addr : '0;
  assign wr_en   = busy && st != POLL;

  always_comb begin
    wr_addr = '0;
    wr_data = '0;
    case (st)
      CLR_SETUP: wr_addr = setup_addr;
      CLR_CTRL:  wr_addr = ctrl_addr;
      WR_CNT:    begin wr_addr = setup_addr; wr_data = setup_sh | (DW'(cnt_q) << CNT_LSB); end
      CLR_ST1:   begin wr_addr = stat_addr;  wr_data = DONE_MASK; end
      WR_TYPE:   begin wr_addr = setup_addr; wr_data = setup_sh | type_bits | (DW'(1) << EN_BIT); end
      WR_REQ:    begin wr_addr = ctrl_addr;  wr_data = ctrl_sh | sel_bits | (DW'(1) << REQ_BIT); end
      CLR_ST2:   begin wr_addr = stat_addr;  wr_data = DONE_MASK; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      setup_sh <= '0;
      ctrl_sh <= '0;
      cnt_q <= '0;
      fast_q <= 1'b0;
      tmo <= '0;
      done <= 1'b0;
      skipped <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      skipped <= 1'b0;
      case (st)
        IDLE: if (start) begin
          timeout_err <= 1'b0;
          if (reject) skipped <= 1'b1;
          else begin
            st <= CLR_SETUP;
            fast_q <= is_fast;
            cnt_q <= settle_cnt;
          end
        end
        CLR_SETUP: begin setup_sh <= '0; st <= CLR_CTRL; end
        CLR_CTRL:  begin ctrl_sh <= '0;  st <= WR_CNT; end
        WR_CNT:    begin setup_sh <= wr_data; st <= CLR_ST1; end
        CLR_ST1:   st <= WR_TYPE;
        WR_TYPE:   begin setup_sh <= wr_data; st <= WR_REQ; end
        WR_REQ:    begin ctrl_sh <= wr_data; tmo <= '0; st <= POLL; end
        POLL: begin
          if (rd_data[DONE_BIT]) st <= CLR_ST2;
          else if (tmo == TW'(TIMEOUT - 1)) begin
            timeout_err <= 1'b1;
            st <= CLR_ST2;
          end else tmo <= tmo + 1'b1;
        end
        CLR_ST2: begin st <= IDLE; done <= 1'b1; end
        default: st <= IDLE;
      endcase
    end
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !wr_en); // R1
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) skipped |-> !busy && !wr_en); // R4
  AST_FIRST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_en && wr_addr == setup_addr && wr_data == '0); // R7
  AST_TIMEOUT_FINISHES: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout_err) |=> done); // R11
  AST_DONE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en && wr_addr == stat_addr && wr_data == DONE_MASK)); // R12
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(done && skipped)); // R13
endmodule

// File: tb/bias_seq_test.sv
module bias_seq_test;
  localparam int TMO = 16;
  localparam logic [7:0] SA = 8'h10, CA = 8'h20, TA = 8'h30;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] opp_code = 0;
  logic preset_en = 0, preset_ok = 0;
  logic [7:0] settle_cnt = 0;
  logic [7:0] setup_addr = SA, ctrl_addr = CA, stat_addr = TA;
  logic wr_en, busy, done, skipped, timeout_err;
  logic [7:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;

  bias_seq #(.TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opp_code(opp_code),
    .preset_en(preset_en), .preset_ok(preset_ok), .settle_cnt(settle_cnt),
    .setup_addr(setup_addr), .ctrl_addr(ctrl_addr), .stat_addr(stat_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done), .skipped(skipped),
    .timeout_err(timeout_err));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] la [0:15];
  logic [31:0] ld [0:15];
  int n = 0, busy_cnt = 0, done_cnt = 0, skip_cnt = 0;
  logic stbit = 0, pend_req = 0, resp_en = 0;
  int resp_delay = 3, cd = 0;

  assign rd_data = (rd_addr == TA) ? {24'h0, stbit, 7'h0} : 32'h0;

  always @(posedge clk) begin
    if (pend_req) stbit <= 1'b1;
    if (wr_en && wr_addr == TA && wr_data[7]) stbit <= 1'b0;
    if (cd == 1) stbit <= 1'b1;
    if (cd > 0) cd <= cd - 1;
    if (wr_en && wr_addr == CA && wr_data[2] && resp_en) cd <= resp_delay;
  end

  always @(negedge clk) begin
    cycles++;
    if (wr_en) begin
      if (n < 16) begin la[n] = wr_addr; ld[n] = wr_data; end
      n++;
    end
    if (busy) busy_cnt++;
    if (done) done_cnt++;
    if (skipped) skip_cnt++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] code, input logic [7:0] cnt, output logic first_busy);
    @(negedge clk);
    n = 0; busy_cnt = 0; done_cnt = 0; skip_cnt = 0;
    opp_code = code; settle_cnt = cnt; start = 1;
    @(negedge clk);
    start = 0;
    first_busy = busy;
    for (int i = 0; i < 200; i++) begin
      if (!busy && (done_cnt + skip_cnt) > 0) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_run(input bit fast, input logic [7:0] cnt, input string tag);
    logic [31:0] tb, sb;
    tb = fast ? 32'h4 : 32'h2;
    sb = fast ? 32'h10 : 32'h08;
    chk(n == 7, "R7 write count", n, 7);
    chk(la[0] == SA && ld[0] == 0, "R7 setup cleared first", ld[0], 0);
    chk(la[1] == CA && ld[1] == 0, "R7 control cleared second", la[1], CA);
    chk(la[2] == SA && ld[2] == {16'h0, cnt, 8'h0}, "R8 settle field", ld[2], {16'h0, cnt, 8'h0});
    chk(la[3] == TA && ld[3] == 32'h80, "R9 pending status clear", ld[3], 32'h80);
    chk(la[4] == SA && ld[4] == ({16'h0, cnt, 8'h0} | tb | 32'h1), {tag, " R10 type+enable"},
        ld[4], {16'h0, cnt, 8'h0} | tb | 32'h1);
    chk(la[5] == CA && ld[5] == (sb | 32'h4), {tag, " R10 select+request"}, ld[5], sb | 32'h4);
    chk(la[6] == TA && ld[6] == 32'h80, "R12 final status clear", ld[6], 32'h80);
    chk(done_cnt == 1 && skip_cnt == 0, "R13 done pulse", done_cnt, 1);
  endtask

  task automatic t_reset;
    chk(!busy && !wr_en && !done && !skipped && !timeout_err, "R1 reset state",
        {busy, wr_en, done, skipped, timeout_err}, 0);
  endtask

  task automatic t_fast;
    logic fb;
    resp_en = 1; resp_delay = 3;
    run(2'd1, 8'hA5, fb);
    chk(fb, "R1 busy after start", fb, 1);
    check_run(1, 8'hA5, "R2");
    chk(!timeout_err, "R13 no error on success", timeout_err, 0);
    chk(!stbit, "R12 status left clear", stbit, 0);
  endtask

  task automatic t_slow;
    logic fb;
    resp_en = 1; resp_delay = 6;
    run(2'd2, 8'h3C, fb);
    check_run(0, 8'h3C, "R3");
    chk(!timeout_err, "R3 no error", timeout_err, 0);
  endtask

  task automatic t_bad_code;
    logic fb;
    resp_en = 1;
    run(2'd0, 8'h11, fb);
    chk(n == 0 && skip_cnt == 1 && done_cnt == 0, "R4 code 0 skipped", n, 0);
    chk(!fb && busy_cnt == 0, "R4 never busy", busy_cnt, 0);
    run(2'd3, 8'h11, fb);
    chk(n == 0 && skip_cnt == 1, "R4 code 3 skipped", n, 0);
  endtask

  task automatic t_zero_addr;
    logic fb;
    ctrl_addr = 0;
    run(2'd1, 8'h22, fb);
    chk(n == 0 && skip_cnt == 1, "R5 zero control addr", n, 0);
    ctrl_addr = CA; stat_addr = 0;
    run(2'd2, 8'h22, fb);
    chk(n == 0 && skip_cnt == 1, "R5 zero status addr", n, 0);
    stat_addr = TA;
  endtask

  task automatic t_preset;
    logic fb;
    resp_en = 1; resp_delay = 2;
    preset_en = 1; preset_ok = 0;
    run(2'd1, 8'h44, fb);
    chk(n == 0 && skip_cnt == 1, "R6 preset failure skipped", n, 0);
    preset_ok = 1;
    run(2'd1, 8'h44, fb);
    chk(n == 7 && done_cnt == 1, "R6 preset success runs", n, 7);
    preset_en = 0; preset_ok = 0;
  endtask

  task automatic t_timeout;
    logic fb;
    resp_en = 0;
    @(negedge clk); pend_req = 1;
    @(negedge clk); pend_req = 0;
    chk(stbit, "R9 stale status planted", stbit, 1);
    run(2'd2, 8'h07, fb);
    check_run(0, 8'h07, "R11");
    chk(timeout_err, "R11 timeout flagged", timeout_err, 1);
    chk(busy_cnt == TMO + 7, "R11 busy length", busy_cnt, TMO + 7);
    resp_en = 1; resp_delay = 1;
    run(2'd1, 8'h01, fb);
    chk(!timeout_err && done_cnt == 1, "R13 error cleared by next start", timeout_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fast();
    t_slow();
    t_bad_code();
    t_zero_addr();
    t_preset();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule